// File: doc/BRIEF.md
# Multi-Mode Operand Address Generator

This block turns one 12-bit operand field into an effective address for a single operand. A separate mode code says how the field is read. The result is either a 16-bit main-memory address or the number of a control register. A full address carries a 5-bit bank number in bits 15:11 and an 11-bit word number in bits 10:0.

The block holds the 32 control registers, each 16 bits wide, that belong to the running program. Registers 24 to 31 also act as the eight index registers. Two modes add an increment to a register after it has been read. Indexed mode only reads its register. One request is taken per clock while `start` is high. Results appear one cycle later with a one-cycle `done` pulse.

Field layout depends on the mode:
- Register-based modes: field[4:0] picks the register and field[10:5] is the increment code.
- Indexed mode: field[9:7] picks the index register and field[6:0] is the offset.
- Direct mode: field[10:0] is the word number.

Top module: `opnd_addr_gen`

## Requirements
- R1: While `rstN` is low and after it is released, `effAddr`, `isReg`, `inactive` and `done` are 0. Register k resets to (k * 16'h0843) mod 2^16.
- R2: A request sampled with `start` high at a rising edge raises `done` for exactly the following cycle. The results appear in that cycle. Without a request, `done` is 0 and the other outputs hold their last values.
- R3: Direct mode (mode 1) returns `effAddr` = {segBank, field[10:0]} with `isReg` 0. Field bit 11 is ignored and no register changes.
- R4: Indirect mode (mode 3) returns the value that register field[4:0] held before the request, with `isReg` 0. That register is then increased by the decoded increment.
- R5: The increment code is field[10:5]. Codes 0 to 32 add that amount, codes 33 to 63 add 32, and code 0 leaves the register unchanged.
- R6: Direct-register mode (mode 2) returns `effAddr` = field[4:0] zero-extended, with `isReg` 1. It post-increments that register exactly as R4 and R5 describe.
- R7: Indexed mode (mode 4) returns (register[24 + field[9:7]] + field[6:0]) mod 2^16 with `isReg` 0. No register is written.
- R8: Post-increments and indexed sums wrap modulo 2^16.
- R9: Mode 0, and the unused codes 5 to 7, give `inactive` 1, `effAddr` 0 and `isReg` 0. No register changes.
- R10: A request in the cycle right after a post-increment sees the incremented register value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, one request per cycle |
| mode | input | 3 | Addressing mode code |
| field | input | 12 | Operand address field |
| segBank | input | 5 | Bank number of the current segment |
| effAddr | output | 16 | Effective address or register number |
| isReg | output | 1 | Result names a control register |
| inactive | output | 1 | Operand is to be ignored |
| done | output | 1 | Result valid pulse |

## Verification
Two events can fall in the same cycle:
- The post-increment of one request writes its register at the same edge that completes that request.
- The next request, issued in the following cycle, reads that same register.

The bench provokes this with unbroken runs of `start` on a single register. Each run alternates indirect, direct-register and indexed requests, and one run walks a pointer across the 16-bit wrap. A behavioural model updates its own register array at each request. Its expected address is compared with the design on every clock, so a stale read or a lost write shows up as a wrong address.

// File: rtl/oag_pkg.sv
package oag_pkg;
  typedef enum logic [2:0] {
    MODE_OFF      = 3'd0,
    MODE_DIRECT   = 3'd1,
    MODE_REGDIR   = 3'd2,
    MODE_INDIRECT = 3'd3,
    MODE_INDEXED  = 3'd4
  } opMode_e;

  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_SEG,
    SRC_REGNUM,
    SRC_PTR,
    SRC_IDX
  } addrSrc_e;

  typedef struct packed {
    logic     load;
    logic     wrEn;
    addrSrc_e src;
  } ctlStrobe_t;
endpackage

// File: rtl/oag_ctrl.sv
module oag_ctrl
  import oag_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [2:0] mode,
  output ctlStrobe_t strb,
  output logic       done
);
  always_comb begin
    strb = '{load: start, wrEn: 1'b0, src: SRC_NONE};
    if (start) begin
      case (mode)
        MODE_DIRECT:   strb.src = SRC_SEG;
        MODE_REGDIR:   begin strb.src = SRC_REGNUM; strb.wrEn = 1'b1; end
        MODE_INDIRECT: begin strb.src = SRC_PTR;    strb.wrEn = 1'b1; end
        MODE_INDEXED:  strb.src = SRC_IDX;
        default:       strb.src = SRC_NONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) done <= 1'b0;
    else       done <= start;
  end

  // R2: done only follows a request and never lasts without one
  assert_done_follows_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(start));
  assert_start_gives_done_R2: assert property (@(posedge clk) disable iff (!rstN)
    start |=> done);
endmodule

// File: rtl/oag_dp.sv
module oag_dp
  import oag_pkg::*;
#(
  parameter int          FIELD_W    = 12,
  parameter int          ADDR_W     = 16,
  parameter int          BANK_W     = 5,
  parameter int          NREG       = 32,
  parameter int          NIDX       = 8,
  parameter int          INDEX_BASE = 24,
  parameter int          INC_W      = 6,
  parameter int          MAX_INC    = 32,
  parameter int          OFS_W      = 7,
  parameter logic [15:0] RST_STRIDE = 16'h0843
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strb,
  input  logic [FIELD_W-1:0] field,
  input  logic [BANK_W-1:0]  segBank,
  output logic [ADDR_W-1:0]  effAddr,
  output logic               isReg,
  output logic               inactive
);
  localparam int WORD_W = ADDR_W - BANK_W;
  localparam int SEL_W  = $clog2(NREG);
  localparam int IDX_W  = $clog2(NIDX);

  logic [ADDR_W-1:0] regs [NREG];
  logic [NREG*ADDR_W-1:0] regsFlat;

  logic [SEL_W-1:0]  ptrSel;
  logic [INC_W-1:0]  incCode;
  logic [ADDR_W-1:0] incAmt;
  logic [IDX_W-1:0]  idxSel;
  logic [SEL_W-1:0]  idxReg;
  logic [OFS_W-1:0]  offset;
  logic [ADDR_W-1:0] ptrVal;
  logic [ADDR_W-1:0] nextAddr;

  assign ptrSel  = field[SEL_W-1:0];
  assign incCode = field[SEL_W +: INC_W];
  assign incAmt  = (int'(incCode) > MAX_INC) ? ADDR_W'(MAX_INC) : ADDR_W'(incCode);
  assign idxSel  = field[OFS_W +: IDX_W];
  assign idxReg  = SEL_W'(INDEX_BASE) + SEL_W'(idxSel);
  assign offset  = field[OFS_W-1:0];
  assign ptrVal  = regs[ptrSel];

  always_comb begin
    case (strb.src)
      SRC_SEG:    nextAddr = {segBank, field[WORD_W-1:0]};
      SRC_REGNUM: nextAddr = ADDR_W'(ptrSel);
      SRC_PTR:    nextAddr = ptrVal;
      SRC_IDX:    nextAddr = regs[idxReg] + ADDR_W'(offset);
      default:    nextAddr = '0;
    endcase
  end

  for (genvar g = 0; g < NREG; g++) begin : gReg
    always_ff @(posedge clk) begin
      if (!rstN)
        regs[g] <= ADDR_W'(g * int'(RST_STRIDE));
      else if (strb.load && strb.wrEn && ptrSel == SEL_W'(g))
        regs[g] <= regs[g] + incAmt;
    end
    assign regsFlat[g*ADDR_W +: ADDR_W] = regs[g];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      effAddr  <= '0;
      isReg    <= 1'b0;
      inactive <= 1'b0;
    end else if (strb.load) begin
      effAddr  <= nextAddr;
      isReg    <= (strb.src == SRC_REGNUM);
      inactive <= (strb.src == SRC_NONE);
    end
  end

  // R7 / R9 / R3: requests without a post-increment leave every register alone
  assert_no_write_without_inc_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && !strb.wrEn) |=> $stable(regsFlat));
  // R4 / R8: the selected register advances by the clamped amount, modulo 2^16
  assert_post_inc_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && strb.wrEn) |=> regs[$past(ptrSel)] == $past(ptrVal) + $past(incAmt));
  // R5: the applied increment never exceeds the limit
  assert_inc_limit_R5: assert property (@(posedge clk) disable iff (!rstN)
    int'(incAmt) <= MAX_INC);
  // R3: direct results carry the segment bank in the upper bits
  assert_direct_bank_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && strb.src == SRC_SEG) |=> effAddr[ADDR_W-1:WORD_W] == $past(segBank));
  // R9: an inactive result is never a register and carries a zero address
  assert_inactive_clean_R9: assert property (@(posedge clk) disable iff (!rstN)
    inactive |-> (!isReg && effAddr == '0));
endmodule

// File: rtl/opnd_addr_gen.sv
module opnd_addr_gen
  import oag_pkg::*;
#(
  parameter int          FIELD_W    = 12,
  parameter int          ADDR_W     = 16,
  parameter int          BANK_W     = 5,
  parameter int          NREG       = 32,
  parameter int          NIDX       = 8,
  parameter int          INDEX_BASE = 24,
  parameter int          MAX_INC    = 32,
  parameter logic [15:0] RST_STRIDE = 16'h0843
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [2:0]         mode,
  input  logic [FIELD_W-1:0] field,
  input  logic [BANK_W-1:0]  segBank,
  output logic [ADDR_W-1:0]  effAddr,
  output logic               isReg,
  output logic               inactive,
  output logic               done
);
  ctlStrobe_t strb;

  oag_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .mode  (mode),
    .strb  (strb),
    .done  (done)
  );

  oag_dp #(
    .FIELD_W    (FIELD_W),
    .ADDR_W     (ADDR_W),
    .BANK_W     (BANK_W),
    .NREG       (NREG),
    .NIDX       (NIDX),
    .INDEX_BASE (INDEX_BASE),
    .MAX_INC    (MAX_INC),
    .RST_STRIDE (RST_STRIDE)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .field    (field),
    .segBank  (segBank),
    .effAddr  (effAddr),
    .isReg    (isReg),
    .inactive (inactive)
  );
endmodule

// File: tb/sim_opnd_addr_gen.sv
`timescale 1ns/1ps
module sim_opnd_addr_gen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  mode = '0;
  logic [11:0] field = '0;
  logic [4:0]  segBank = '0;
  logic [15:0] effAddr;
  logic        isReg, inactive, done;

  always #10 clk = ~clk;

  opnd_addr_gen u0 (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .field(field),
    .segBank(segBank), .effAddr(effAddr), .isReg(isReg), .inactive(inactive), .done(done)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // behavioural reference model
  int    mReg [32];
  int    eAddr = 0;
  bit    eIsReg = 0, eInact = 0, eDone = 0;
  string tag = "R1";

  always @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < 32; k++) mReg[k] = (k * 'h843) % 65536;
      eAddr = 0; eIsReg = 0; eInact = 0; eDone = 0; tag = "R1";
    end else begin
      eDone = start;
      if (start) begin
        int sel, inc, ix;
        sel = field % 32;
        inc = (field / 32) % 64;
        if (inc > 32) inc = 32;
        eIsReg = 0; eInact = 0;
        case (mode)
          1: begin eAddr = segBank * 2048 + (field % 2048); tag = "R3"; end
          2: begin eAddr = sel; eIsReg = 1; mReg[sel] = (mReg[sel] + inc) % 65536; tag = "R6"; end
          3: begin eAddr = mReg[sel]; mReg[sel] = (mReg[sel] + inc) % 65536; tag = "R4"; end
          4: begin ix = 24 + (field / 128) % 8; eAddr = (mReg[ix] + field % 128) % 65536; tag = "R7"; end
          default: begin eAddr = 0; eInact = 1; tag = "R9"; end
        endcase
      end
    end
  end

  string phase = "R1";
  always @(negedge clk) begin
    if (!finished) begin
      checks++;
      if (effAddr !== 16'(eAddr) || isReg !== eIsReg || inactive !== eInact || done !== eDone) begin
        fails++;
        $display("FAIL %s/%s t=%0t: actual addr=%h isReg=%b inact=%b done=%b expected addr=%h isReg=%b inact=%b done=%b",
                 tag, phase, $time, effAddr, isReg, inactive, done, 16'(eAddr), eIsReg, eInact, eDone);
      end
    end
  end

  task automatic issue(input int m, input int f, input int b);
    @(negedge clk);
    start = 1'b1; mode = 3'(m); field = 12'(f); segBank = 5'(b);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      start = 1'b0; mode = 3'(($time / 20) % 8); field = 12'h5A5;
    end
  endtask

  function automatic int ptrField(input int inc, input int sel);
    return inc * 32 + sel;
  endfunction

  function automatic int idxField(input int sel, input int ofs);
    return sel * 128 + ofs;
  endfunction

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    phase = "R1"; idle(2);
    // R1: read every reset value with a zero increment, back to back
    for (int k = 0; k < 32; k++) issue(3, ptrField(0, k), 0);
    phase = "R2"; idle(3);
    // R3: direct mode, field bit 11 ignored
    phase = "R3";
    issue(1, 12'h7FF, 31); issue(1, 12'h800, 0); issue(1, 12'hABC, 17); idle(2);
    // R5: increment decoding, clamping above 32
    phase = "R5";
    issue(3, ptrField(63, 5), 0); issue(3, ptrField(33, 5), 0); issue(3, ptrField(32, 5), 0);
    issue(3, ptrField(1, 5), 0);  issue(3, ptrField(0, 5), 0);  idle(1);
    // R6 / R10: direct-register then pointer use in consecutive cycles
    phase = "R10";
    issue(2, ptrField(7, 9), 0); issue(3, ptrField(4, 9), 0); issue(2, ptrField(0, 9), 0);
    issue(3, ptrField(0, 9), 0); idle(1);
    // R7: indexed mode leaves the register untouched; read it again
    phase = "R7";
    for (int s = 0; s < 8; s++) begin
      issue(4, idxField(s, 127), 0); issue(4, idxField(s, 0), 0);
    end
    // R10: post-increment on an index register, then indexed read next cycle
    issue(3, ptrField(20, 26), 0); issue(4, idxField(2, 3), 0); idle(1);
    // R9: inactive and unused mode codes, followed by reads of the same register
    phase = "R9";
    for (int m = 5; m < 8; m++) issue(m, ptrField(32, 27), 3);
    issue(0, 12'hFFF, 31); issue(4, idxField(3, 0), 0); issue(3, ptrField(0, 27), 0);
    idle(2);
    // R8: walk a pointer across the 16-bit wrap, mixed with indexed sums
    phase = "R8";
    for (int i = 0; i < 70; i++) begin
      issue(3, ptrField(32, 30), 0);
      issue(4, idxField(6, 127), 0);
    end
    issue(2, ptrField(45, 30), 0); issue(4, idxField(6, 0), 0);
    idle(3);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual run still busy, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule